// File: doc/BRIEF.md
# Cascadable Reload Down-Counter Timer Bank

This block holds four 8-bit interval timers behind a small byte-addressed register bus. Each timer has three registers: a mode register, a reload value and a read-only count. A running timer counts down once per clock. When its period ends, it reloads from its reload value and raises a one-cycle pulse on its own underflow output.

Any timer except timer 0 can take its clock from the timer below it. Two, three or four neighbours then act as one down-counter of 16, 24 or 32 bits. Their reload values are joined into one wider period, with the lowest timer as the least significant byte. Only the highest member of such a chain reports the end of the period. Bus accesses may be 1, 2 or 4 bytes wide and follow fixed packing rules. An illegal access sets a sticky error flag and changes nothing.

Top module: `cascTimerBank`

## Requirements
- R1: A mode byte has enable in bit 7, load in bit 6 and clock select in bits 1:0, where 2'b00 selects the internal clock and 2'b11 selects cascade from timer n-1. A mode write is an error if any of bits 5:2 is set or if clock select is 2'b01 or 2'b10.
- R2: A mode write that sets enable and load together is an error. A write of cascade clock select to timer 0 is also an error. An erroneous write leaves the mode register unchanged.
- R3: While a timer is disabled, a write to its reload value also sets its count, so the count reads back the new value at once. A mode write that sets enable or load copies the reload value into the count.
- R4: A single timer enabled on the internal clock with reload value B > 0 pulses its underflow output for exactly one cycle, B cycles after the enabling write. It then pulses every B cycles.
- R5: A reload write while the timer runs does not change the period in progress. The new value is used from the next reload onward.
- R6: Timers n+1, n+2, ... that are enabled in cascade mode extend a chain headed by timer n, which is enabled on the internal clock. The chain ends at the first timer that is not cascaded. Timer n+k supplies byte k of the period, so a pair with reload values lo and hi has a period of hi*256+lo cycles.
- R7: A chain pulses only the underflow output of its highest member. The lower members never pulse.
- R8: Mode registers are at addresses 0x00-0x03, reload values at 0x10-0x13 and counts at 0x20-0x23. The timer index is address bits 1:0. Any other address is an error, and a read of it returns 0.
- R9: A write to a count address is an error and has no effect.
- R10: Size code 0 is a 1-byte access, 1 is a 2-byte access and 2 is a 4-byte access. A 2-byte access at timer n (n = 0 or 2) puts timer n in bits 15:8 and timer n+1 in bits 7:0. A 4-byte access at timer 0 puts timer 0 in bits 31:24 down to timer 3 in bits 7:0. A 2-byte access at an odd index, a 4-byte access at a nonzero index, and size code 3 are errors. Unused read bits are 0.
- R11: Mode registers accept only 1-byte writes. A wider mode write is an error.
- R12: A chain whose combined count is zero does not count and never pulses.
- R13: A count read returns the reload value while the timer is disabled and the remaining count while it is enabled.
- R14: The error flag is 0 after reset. It stays 1 from the first error until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address |
| busSize | input | 2 | Access size code |
| busWdata | input | 32 | Write data, right-aligned |
| busRdata | output | 32 | Read data for the current address and size |
| errFlag | output | 1 | Sticky access error |
| underflow | output | 4 | One-cycle period-end pulse per timer |

## Verification
Single timers run with random reload values on random timers. A wrong reload point, or an off-by-one between the enabling write and the first pulse, shows up as a wrong pulse cycle. Random two-timer chains at different heads, including a low byte of zero, separate correct borrow propagation from a per-byte restart. They also check that the lower member stays silent. Directed cases cover a reload write in mid-period, a zero period, a count read before and after stopping, every packing shape, and each illegal access followed by a readback of the register it could have changed.

// File: rtl/tmrPkg.sv
`timescale 1ns/1ps
package tmrPkg;
  parameter int NT = 4;                 // timers in the bank
  parameter int BW = 8;                 // bits per timer
  localparam int AW = 8;                // bus address width
  localparam int DW = NT * BW;          // widest access
  localparam int IW = $clog2(NT);       // timer index bits
  localparam int EN_BIT = 7;
  localparam int LD_BIT = 6;
  localparam logic [1:0] CLK_INT  = 2'b00;
  localparam logic [1:0] CLK_CASC = 2'b11;

  typedef struct packed {
    logic [NT-1:0]         modeWe;
    logic [NT-1:0]         baseWe;
    logic [NT-1:0][BW-1:0] wrByte;
  } tmrStrobe_t;
endpackage

// File: rtl/tmrCtrl.sv
`timescale 1ns/1ps
module tmrCtrl
  import tmrPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busSel,
  input  logic                  busWr,
  input  logic [AW-1:0]         busAddr,
  input  logic [1:0]            busSize,
  input  logic [DW-1:0]         busWdata,
  input  logic [NT-1:0][BW-1:0] modeQ,
  input  logic [NT-1:0][BW-1:0] baseQ,
  input  logic [NT-1:0][BW-1:0] cntView,
  output tmrStrobe_t            stb,
  output logic [DW-1:0]         busRdata,
  output logic                  errFlag
);
  logic [1:0]    region;
  logic [IW-1:0] idx;
  logic          addrOk, sizeOk, modeBad, accErr;
  logic [BW-1:0] modeVal;

  always_comb begin
    int nb;
    int k;
    int lane;
    region  = busAddr[5:4];
    idx     = busAddr[IW-1:0];
    addrOk  = (busAddr[7:6] == '0) && (busAddr[3:IW] == '0) && (region != 2'd3);
    nb      = 1 << busSize;
    sizeOk  = (busSize != 2'd3) && ((int'(idx) % nb) == 0) && (int'(idx) + nb <= NT);
    modeVal = busWdata[BW-1:0];
    modeBad = (modeVal[5:2] != '0) || (modeVal[EN_BIT] && modeVal[LD_BIT]) ||
              (modeVal[1:0] == 2'b01) || (modeVal[1:0] == 2'b10) ||
              ((idx == '0) && (modeVal[1:0] == CLK_CASC));
    accErr  = busSel && (!addrOk || !sizeOk || (busWr && region == 2'd2) ||
              (busWr && region == 2'd0 && (busSize != 2'd0 || modeBad)));
    stb      = '0;
    busRdata = '0;
    for (int t = 0; t < NT; t++) begin
      k = t - int'(idx);
      if (addrOk && sizeOk && k >= 0 && k < nb) begin
        lane = nb - 1 - k;
        stb.wrByte[t] = busWdata[lane*BW +: BW];
        case (region)
          2'd0:    busRdata[lane*BW +: BW] = modeQ[t];
          2'd1:    busRdata[lane*BW +: BW] = baseQ[t];
          default: busRdata[lane*BW +: BW] = cntView[t];
        endcase
        if (busSel && busWr && !accErr) begin
          stb.modeWe[t] = (region == 2'd0);
          stb.baseWe[t] = (region == 2'd1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) errFlag <= 1'b0;
    else if (accErr) errFlag <= 1'b1;
  end
endmodule

// File: rtl/tmrCore.sv
`timescale 1ns/1ps
module tmrCore
  import tmrPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  tmrStrobe_t            stb,
  output logic [NT-1:0][BW-1:0] modeQ,
  output logic [NT-1:0][BW-1:0] baseQ,
  output logic [NT-1:0][BW-1:0] cntQ,
  output logic [NT-1:0][BW-1:0] cntView,
  output logic [NT-1:0]         underflow
);
  logic [NT-1:0] en, head, cascIn, member, top, fire, chZero, borrow, oneSo, zeroSo;

  // chain formation, borrow ripple and end-of-period detection
  always_comb begin
    logic memPrev, oneC, zeroC, borPrev, prevZero, fc, zc, cascAbove;
    memPrev = 1'b0; oneC = 1'b0; zeroC = 1'b0; borPrev = 1'b0; prevZero = 1'b0;
    for (int j = 0; j < NT; j++) begin
      en[j]     = modeQ[j][EN_BIT];
      head[j]   = en[j] && (modeQ[j][1:0] == CLK_INT);
      cascIn[j] = (j != 0) && en[j] && (modeQ[j][1:0] == CLK_CASC) && memPrev;
      member[j] = head[j] || cascIn[j];
      if (head[j]) begin
        oneC      = (cntQ[j] == 1);
        zeroC     = (cntQ[j] == 0);
        borrow[j] = 1'b1;
      end else begin
        oneC      = oneC && (cntQ[j] == 0);
        zeroC     = zeroC && (cntQ[j] == 0);
        borrow[j] = cascIn[j] && borPrev && prevZero;
      end
      oneSo[j]  = oneC;
      zeroSo[j] = zeroC;
      memPrev   = member[j];
      borPrev   = borrow[j];
      prevZero  = (cntQ[j] == 0);
    end
    fc = 1'b0; zc = 1'b0; cascAbove = 1'b0;
    for (int j = NT - 1; j >= 0; j--) begin
      top[j] = member[j] && !cascAbove;
      if (top[j]) begin
        fc = oneSo[j];
        zc = zeroSo[j];
      end
      fire[j]   = member[j] && fc;
      chZero[j] = member[j] && zc;
      cascAbove = cascIn[j];
    end
  end

  always_comb begin
    for (int j = 0; j < NT; j++) cntView[j] = en[j] ? cntQ[j] : baseQ[j];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ     <= '0;
      baseQ     <= '0;
      cntQ      <= '0;
      underflow <= '0;
    end else begin
      for (int j = 0; j < NT; j++) begin
        if (stb.modeWe[j]) begin
          modeQ[j] <= stb.wrByte[j];
          if (stb.wrByte[j][EN_BIT] || stb.wrByte[j][LD_BIT]) cntQ[j] <= baseQ[j];
        end else if (fire[j]) begin
          cntQ[j] <= baseQ[j];
        end else if (member[j] && !chZero[j] && borrow[j]) begin
          cntQ[j] <= cntQ[j] - 1'b1;
        end
        if (stb.baseWe[j]) begin
          baseQ[j] <= stb.wrByte[j];
          if (!en[j]) cntQ[j] <= stb.wrByte[j];
        end
        underflow[j] <= top[j] && fire[j];
      end
    end
  end
endmodule

// File: rtl/cascTimerBank.sv
`timescale 1ns/1ps
module cascTimerBank
  import tmrPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          busSel,
  input  logic          busWr,
  input  logic [AW-1:0] busAddr,
  input  logic [1:0]    busSize,
  input  logic [DW-1:0] busWdata,
  output logic [DW-1:0] busRdata,
  output logic          errFlag,
  output logic [NT-1:0] underflow
);
  tmrStrobe_t            stb;
  logic [NT-1:0][BW-1:0] modeQ, baseQ, cntQ, cntView;

  tmrCtrl uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busSize(busSize), .busWdata(busWdata), .modeQ(modeQ), .baseQ(baseQ),
    .cntView(cntView), .stb(stb), .busRdata(busRdata), .errFlag(errFlag)
  );

  tmrCore uCore (
    .clk(clk), .rstN(rstN), .stb(stb), .modeQ(modeQ), .baseQ(baseQ),
    .cntQ(cntQ), .cntView(cntView), .underflow(underflow)
  );
endmodule

// File: rtl/tmrChecker.sv
`timescale 1ns/1ps
module tmrChecker
  import tmrPkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  busSel,
  input logic                  busWr,
  input logic [AW-1:0]         busAddr,
  input logic [1:0]            busSize,
  input logic                  errFlag,
  input logic [NT-1:0]         underflow,
  input logic [NT-1:0][BW-1:0] modeQ,
  input logic [NT-1:0][BW-1:0] cntQ
);
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag); // R14

  AST_CNT_WR_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr[7:4] == 4'h2) |=> errFlag); // R9

  AST_MODE_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr[7:4] == 4'h0 && busSize != 2'd0) |=> errFlag); // R11

  AST_T0_NOCASC: assert property (@(posedge clk) disable iff (!rstN)
    modeQ[0][1:0] != CLK_CASC); // R2

  for (genvar j = 0; j < NT; j++) begin : gPer
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
      (modeQ[j][5:2] == '0) && !(modeQ[j][EN_BIT] && modeQ[j][LD_BIT])); // R1

    AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
      (!modeQ[j][EN_BIT] && !(busSel && busWr)) |=> $stable(cntQ[j])); // R13
  end

  for (genvar j = 0; j < NT - 1; j++) begin : gTop
    AST_TOP_ONLY: assert property (@(posedge clk) disable iff (!rstN)
      underflow[j] |-> !($past(modeQ[j+1][EN_BIT]) && $past(modeQ[j+1][1:0]) == CLK_CASC)); // R7
  end
endmodule

bind cascTimerBank tmrChecker chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .busSize(busSize), .errFlag(errFlag), .underflow(underflow), .modeQ(modeQ), .cntQ(cntQ)
);

// File: tb/cascTimerBank_test.sv
`timescale 1ns/1ps
module cascTimerBank_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        busSel, busWr;
  logic [7:0]  busAddr;
  logic [1:0]  busSize;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic        errFlag;
  logic [3:0]  underflow;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cascTimerBank uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busSize(busSize), .busWdata(busWdata), .busRdata(busRdata),
    .errFlag(errFlag), .underflow(underflow)
  );

  function automatic int chainPeriod(input int lo, input int hi);
    return hi * 256 + lo;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busSize = s; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [1:0] s, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a; busSize = s;
    #1 d = busRdata;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic waitPulse(input int j, input int maxc, output int k, output int others);
    k = -1;
    others = 0;
    for (int c = 1; c <= maxc; c++) begin
      @(negedge clk);
      others += $countones(underflow & ~(4'b1 << j));
      if (underflow[j]) begin
        k = c;
        break;
      end
    end
  endtask

  task automatic errCase(input string tag, input bit isWr, input logic [7:0] a,
                         input logic [1:0] s, input logic [31:0] d,
                         input logic [7:0] ra, input logic [31:0] rexp);
    logic [31:0] tmp;
    doReset();
    if (isWr) wr(a, s, d);
    else rd(a, s, tmp);
    chk({tag, " error flag"}, {31'b0, errFlag}, 32'd1);
    rd(ra, 2'b00, tmp);
    chk({tag, " state kept"}, tmp, rexp);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int k, oth;
    void'($urandom(32'h5EED));
    rstN = 1'b0; busSel = 1'b0; busWr = 1'b0; busAddr = '0; busSize = '0; busWdata = '0;
    @(negedge clk);
    doReset();

    // R14 reset state, R13 count reads reload value of an idle timer
    chk("R14 error flag after reset", {31'b0, errFlag}, 32'd0);
    chk("R4 no pulse after reset", {28'b0, underflow}, 32'd0);
    rd(8'h20, 2'b00, d);
    chk("R13 idle count after reset", d, 32'd0);

    // R4 single timer period, pulse width, periodic reload
    wr(8'h11, 2'b00, 32'd7);
    wr(8'h01, 2'b00, 32'h80);
    waitPulse(1, 100, k, oth);
    chk("R4 first pulse cycle", k, 32'd7);
    @(negedge clk);
    chk("R4 pulse lasts one cycle", {31'b0, underflow[1]}, 32'd0);
    waitPulse(1, 100, k, oth);
    chk("R4 second period", k, 32'd6);
    wr(8'h01, 2'b00, 32'h00);

    // R4 random single timers
    for (int it = 0; it < 6; it++) begin
      int j;
      int b;
      j = $urandom % 4;
      b = 1 + $urandom % 40;
      wr(8'h10 + 8'(j), 2'b00, 32'(b));
      wr(8'h00 + 8'(j), 2'b00, 32'h80);
      waitPulse(j, 100, k, oth);
      chk($sformatf("R4 random timer %0d period %0d", j, b), k, 32'(b));
      wr(8'h00 + 8'(j), 2'b00, 32'h00);
    end

    // R13 running count vs stopped count
    wr(8'h11, 2'b00, 32'd20);
    wr(8'h01, 2'b00, 32'h80);
    repeat (3) @(negedge clk);
    rd(8'h21, 2'b00, d);
    chk("R13 remaining count while running", d, 32'd17);
    wr(8'h01, 2'b00, 32'h00);
    rd(8'h21, 2'b00, d);
    chk("R13 stopped count reads reload value", d, 32'd20);

    // R5 deferred reload write
    wr(8'h12, 2'b00, 32'd10);
    wr(8'h02, 2'b00, 32'h80);
    wr(8'h12, 2'b00, 32'd5);
    waitPulse(2, 50, k, oth);
    chk("R5 current period kept", k, 32'd9);
    waitPulse(2, 50, k, oth);
    chk("R5 new value after reload", k, 32'd5);
    wr(8'h02, 2'b00, 32'h00);

    // R3 disabled reload write sets count
    wr(8'h12, 2'b00, 32'd33);
    rd(8'h22, 2'b00, d);
    chk("R3 idle write sets count", d, 32'd33);
    wr(8'h02, 2'b00, 32'h80);
    waitPulse(2, 60, k, oth);
    chk("R3 run starts from written value", k, 32'd33);
    wr(8'h02, 2'b00, 32'h00);

    // R6 R7 directed chain 0->1, reload via 2-byte write
    wr(8'h10, 2'b01, 32'h0201);
    wr(8'h01, 2'b00, 32'h83);
    wr(8'h00, 2'b00, 32'h80);
    waitPulse(1, 600, k, oth);
    chk("R6 chain period", k, chainPeriod(2, 1));
    chk("R7 lower member silent", oth, 32'd0);
    wr(8'h00, 2'b00, 32'h00);
    wr(8'h01, 2'b00, 32'h00);

    // R6 R7 random chains
    for (int it = 0; it < 3; it++) begin
      int p;
      int lo;
      int hi;
      p  = 1 + $urandom % 2;
      lo = (it == 0) ? 0 : $urandom % 256;
      hi = 1 + $urandom % 2;
      wr(8'h10 + 8'(p), 2'b00, 32'(lo));
      wr(8'h11 + 8'(p), 2'b00, 32'(hi));
      wr(8'h01 + 8'(p), 2'b00, 32'h83);
      wr(8'h00 + 8'(p), 2'b00, 32'h80);
      waitPulse(p + 1, 800, k, oth);
      chk($sformatf("R6 random chain head %0d", p), k, chainPeriod(lo, hi));
      chk("R7 random chain lower silent", oth, 32'd0);
      wr(8'h00 + 8'(p), 2'b00, 32'h00);
      wr(8'h01 + 8'(p), 2'b00, 32'h00);
    end

    // R12 zero period
    wr(8'h13, 2'b00, 32'd0);
    wr(8'h03, 2'b00, 32'h80);
    waitPulse(3, 300, k, oth);
    chk("R12 zero period never pulses", k, 32'hFFFF_FFFF);
    rd(8'h23, 2'b00, d);
    chk("R12 zero count held", d, 32'd0);
    wr(8'h03, 2'b00, 32'h00);

    // R10 packing
    wr(8'h10, 2'b10, 32'h1122_3344);
    rd(8'h10, 2'b00, d);
    chk("R10 byte timer 0", d, 32'h11);
    rd(8'h13, 2'b00, d);
    chk("R10 byte timer 3", d, 32'h44);
    rd(8'h12, 2'b01, d);
    chk("R10 half at timer 2", d, 32'h3344);
    rd(8'h10, 2'b10, d);
    chk("R10 word at timer 0", d, 32'h1122_3344);
    wr(8'h00, 2'b00, 32'h40);
    wr(8'h01, 2'b00, 32'h03);
    rd(8'h00, 2'b01, d);
    chk("R1 R10 legal modes packed", d, 32'h4003);
    rd(8'h00, 2'b10, d);
    chk("R8 mode word read", d, 32'h4003_0000);
    chk("R8 legal accesses raise no error", {31'b0, errFlag}, 32'd0);

    // error cases, each from reset
    errCase("R1 reserved bit", 1'b1, 8'h02, 2'b00, 32'h84, 8'h02, 32'h00);
    errCase("R1 clock select 01", 1'b1, 8'h02, 2'b00, 32'h01, 8'h02, 32'h00);
    errCase("R2 enable with load", 1'b1, 8'h01, 2'b00, 32'hC0, 8'h01, 32'h00);
    errCase("R2 timer 0 cascade", 1'b1, 8'h00, 2'b00, 32'h03, 8'h00, 32'h00);
    errCase("R9 count write", 1'b1, 8'h20, 2'b00, 32'h55, 8'h20, 32'h00);
    errCase("R10 half at odd index", 1'b1, 8'h11, 2'b01, 32'hAABB, 8'h11, 32'h00);
    errCase("R10 size code 3", 1'b0, 8'h10, 2'b11, 32'h0, 8'h10, 32'h00);
    errCase("R11 wide mode write", 1'b1, 8'h00, 2'b01, 32'h8000, 8'h00, 32'h00);
    errCase("R8 unmapped region", 1'b0, 8'h30, 2'b00, 32'h0, 8'h00, 32'h00);
    errCase("R8 gap address", 1'b1, 8'h14, 2'b00, 32'h12, 8'h10, 32'h00);

    // R14 sticky then cleared by reset
    wr(8'h10, 2'b00, 32'd5);
    chk("R14 flag sticky after legal write", {31'b0, errFlag}, 32'd1);
    doReset();
    chk("R14 flag cleared by reset", {31'b0, errFlag}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule